// File: doc/BRIEF.md
# Path Trace Monitor

The block watches the path-trace overhead byte, which arrives once per frame as a single-cycle strobe. It records the bytes in a trace buffer of DEPTH entries (64 by default) and reports a trace mismatch state. A 3-bit mode input selects how bytes are placed in the buffer and what they are compared against. The block can compare each byte with the byte received one buffer length earlier. It can align on a carriage-return / line-feed pair or on a byte whose top bit is set, and then check each location against what it held before. It can filter a single byte for persistence. It can also check the aligned stream against an expected message that is written through a separate port.

Any change of the mismatch state, and any byte accepted by the persistence filter, sets a sticky delta bit. A clear strobe resets the delta bit, and an interrupt output presents it unless the mask input is high. The captured buffer can be read at any time through a combinational read port. The trace message carries no CRC and the block checks none.

Top module: `trace_monitor`

## Requirements
- R1: Reset clears the mismatch state, the delta bit, the interrupt and every capture buffer location to zero.
- R2: Mode 000 writes every strobed byte to buffer locations 0, 1, 2, … in turn, wrapping after DEPTH-1 and starting from 0 on mode entry. The mismatch state is set by each byte that differs from the byte the same location received earlier in this mode, and cleared by each byte that matches or that hits a location not yet written in this mode.
- R3: Mode 001 stores nothing until it sees byte 0x0D followed directly by 0x0A. The byte after the 0x0A goes to location 0 and the following bytes go to consecutive locations, wrapping after DEPTH-1. Every later 0x0D 0x0A pair sends the next byte to location 0 again.
- R4: Mode 010 writes any byte with bit 7 set to location 0 and the byte after it to location 1. Aligned bytes without bit 7 go to consecutive locations. Bytes before the first such marker are not stored.
- R5: In modes 001 and 010, a byte that differs from the content its location received earlier in this mode sets the mismatch state in the same update.
- R6: In modes 001, 010 and 100, the mismatch state clears after DEPTH consecutive stored bytes show no difference. Any difference restarts that count.
- R7: Mode 100 aligns as in mode 001, still fills the capture buffer, and compares each stored byte with the expected memory at the same location. Setting and clearing follow R5 and R6. The expected memory is written through its own port in any mode, and a write takes effect from the next clock.
- R8: Mode 011 accepts a byte into location 0 once it has arrived on the latest N consecutive strobes, where N is the persistence count input and 0 counts as 1. The byte must also differ from the current content of location 0. Each acceptance sets the delta bit, and the mismatch state stays 0.
- R9: Modes 101, 110 and 111 store nothing and hold the mismatch state at 0.
- R10: In the clock where the mode input differs from the mode of the previous clock, the strobed byte is ignored. The alignment, history and counters restart, and the mismatch state clears.
- R11: The delta bit is set in the update where the mismatch state changes or where R8 accepts a byte. It is cleared by a delta_clr pulse in an update with no such event, and setting wins over clearing.
- R12: irq equals the delta bit while irq_mask is 0. irq is 0 while irq_mask is 1, and the mask leaves the delta bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Monitoring mode select |
| persist_n | input | CNT_W | Persistence count for mode 011 (0 acts as 1) |
| frame_stb | input | 1 | One pulse per frame: trace_byte is valid |
| trace_byte | input | BYTE_W | Received path-trace byte |
| exp_wr_en | input | 1 | Expected memory write enable |
| exp_wr_addr | input | log2(DEPTH) | Expected memory write location |
| exp_wr_data | input | BYTE_W | Expected memory write data |
| rd_addr | input | log2(DEPTH) | Capture buffer read location |
| rd_data | output | BYTE_W | Capture buffer content at rd_addr (combinational) |
| delta_clr | input | 1 | Clears the delta bit |
| irq_mask | input | 1 | Masks irq when high |
| mismatch | output | 1 | Trace mismatch state |
| delta | output | 1 | Sticky change indicator |
| irq | output | 1 | Delta gated by the mask |

## Verification
The bench builds the block with its default parameters: DEPTH 64, BYTE_W 8, CNT_W 4 and the expected memory present. It can therefore send whole 64-byte messages with their 0x0D 0x0A trailer and catch the wrap of the location pointer. With these defaults it also runs the clean-pass count to its full length, exercises a persistence count of both 3 and 0, and reaches mode 100. Messages are sent for several passes with single-byte faults inserted. These show that one fault needs two clean passes to clear in the history modes but only one in the expected-message mode.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

   typedef enum logic [2:0] {
      MODE_RROBIN  = 3'b000,
      MODE_CRLF    = 3'b001,
      MODE_MSB     = 3'b010,
      MODE_PERSIST = 3'b011,
      MODE_EXPECT  = 3'b100,
      MODE_OFF     = 3'b111
   } ptm_mode_e;

   localparam logic [7:0] MARK_CR = 8'h0D;
   localparam logic [7:0] MARK_LF = 8'h0A;

endpackage

// File: rtl/ptm_locator.sv
// Decides for every accepted byte whether, and where, it lands in the buffer.
module ptm_locator
   import ptm_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int BYTE_W = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              stb,
   input  ptm_mode_e         mode_e,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              wr_en,
   output logic [AW-1:0]     wr_loc
);

   localparam logic [BYTE_W-1:0] CR_W = BYTE_W'(MARK_CR);
   localparam logic [BYTE_W-1:0] LF_W = BYTE_W'(MARK_LF);

   logic [AW-1:0]     idx_q, idx_n;
   logic              algn_q, algn_n;
   logic [BYTE_W-1:0] prev_q, prev_n;

   always_comb begin
      wr_en  = 1'b0;
      wr_loc = idx_q;
      idx_n  = idx_q;
      algn_n = algn_q;
      prev_n = prev_q;
      if (restart) begin
         idx_n  = '0;
         algn_n = 1'b0;
         prev_n = '0;
      end else if (stb) begin
         case (mode_e)
            MODE_RROBIN: begin
               wr_en = 1'b1;
               idx_n = idx_q + AW'(1);
            end
            MODE_CRLF, MODE_EXPECT: begin
               prev_n = byte_in;
               if (algn_q) begin
                  wr_en = 1'b1;
                  idx_n = idx_q + AW'(1);
               end
               if (prev_q == CR_W && byte_in == LF_W) begin
                  algn_n = 1'b1;
                  idx_n  = '0;
               end
            end
            MODE_MSB: begin
               if (byte_in[BYTE_W-1]) begin
                  wr_en  = 1'b1;
                  wr_loc = '0;
                  idx_n  = AW'(1);
                  algn_n = 1'b1;
               end else if (algn_q) begin
                  wr_en = 1'b1;
                  idx_n = idx_q + AW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         algn_q <= 1'b0;
         prev_q <= '0;
      end else begin
         idx_q  <= idx_n;
         algn_q <= algn_n;
         prev_q <= prev_n;
      end
   end

endmodule

// File: rtl/ptm_store.sv
// Capture buffer with per-location written flags, plus the optional expected memory.
module ptm_store #(
   parameter int DEPTH      = 64,
   parameter int BYTE_W     = 8,
   parameter bit HAS_EXPECT = 1'b1,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_loc,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              exp_wr_en,
   input  logic [AW-1:0]     exp_wr_addr,
   input  logic [BYTE_W-1:0] exp_wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] hist_byte,
   output logic              hist_valid,
   output logic [BYTE_W-1:0] exp_byte,
   output logic [BYTE_W-1:0] loc0_byte
);

   logic [BYTE_W-1:0] cap_q [DEPTH];
   logic [DEPTH-1:0]  seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cap_q[i] <= '0;
         seen_q <= '0;
      end else begin
         if (restart) seen_q <= '0;
         if (wr_en) begin
            cap_q[wr_loc]  <= wr_data;
            seen_q[wr_loc] <= 1'b1;
         end
      end
   end

   assign rd_data    = cap_q[rd_addr];
   assign hist_byte  = cap_q[wr_loc];
   assign hist_valid = seen_q[wr_loc];
   assign loc0_byte  = cap_q[0];

   generate
      if (HAS_EXPECT) begin : g_exp
         logic [BYTE_W-1:0] exp_q [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) exp_q[i] <= '0;
            end else if (exp_wr_en) begin
               exp_q[exp_wr_addr] <= exp_wr_data;
            end
         end
         assign exp_byte = exp_q[wr_loc];
      end else begin : g_noexp
         assign exp_byte = '0;
      end
   endgenerate

endmodule

// File: rtl/ptm_persist.sv
// Single-byte persistence filter: a byte must repeat N times before it is taken.
module ptm_persist #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              active,
   input  logic              stb,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic [CNT_W-1:0]  thresh,
   input  logic [BYTE_W-1:0] loc0_byte,
   output logic              accept
);

   logic [BYTE_W-1:0] cand_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n, need;

   always_comb begin
      need = (thresh == '0) ? CNT_W'(1) : thresh;
      if (byte_in != cand_q)      cnt_n = CNT_W'(1);
      else if (cnt_q == '1)       cnt_n = cnt_q;
      else                        cnt_n = cnt_q + CNT_W'(1);
      accept = active && stb && (cnt_n >= need) && (byte_in != loc0_byte);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= '0;
         cnt_q  <= '0;
      end else if (restart) begin
         cand_q <= '0;
         cnt_q  <= '0;
      end else if (active && stb) begin
         cand_q <= byte_in;
         cnt_q  <= cnt_n;
      end
   end

endmodule

// File: rtl/trace_monitor.sv
module trace_monitor
   import ptm_pkg::*;
#(
   parameter int DEPTH      = 64,
   parameter int BYTE_W     = 8,
   parameter int CNT_W      = 4,
   parameter bit HAS_EXPECT = 1'b1,
   localparam int AW        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic [CNT_W-1:0]  persist_n,
   input  logic              frame_stb,
   input  logic [BYTE_W-1:0] trace_byte,
   input  logic              exp_wr_en,
   input  logic [AW-1:0]     exp_wr_addr,
   input  logic [BYTE_W-1:0] exp_wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              delta_clr,
   input  logic              irq_mask,
   output logic              mismatch,
   output logic              delta,
   output logic              irq
);

   localparam int CLW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("trace_monitor: DEPTH must be a power of two of at least 2");
      end
      if (BYTE_W < 8) begin : g_bad_width
         $error("trace_monitor: BYTE_W must be at least 8");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("trace_monitor: CNT_W must be at least 1");
      end
   endgenerate

   logic [2:0]        mode_q;
   logic              restart, stb_eff;
   ptm_mode_e         mode_e;
   logic              loc_wr, p_accept, st_wr;
   logic [AW-1:0]     loc_idx, st_loc;
   logic [BYTE_W-1:0] hist_byte, exp_byte, loc0_byte, ref_byte;
   logic              hist_valid, ref_valid, bad;
   logic              mis_q, mis_n, dlt_q, dlt_n;
   logic [CLW-1:0]    clean_q, clean_n;

   assign restart = (mode != mode_q);
   assign stb_eff = frame_stb && !restart;

   generate
      if (HAS_EXPECT) begin : g_mode_full
         assign mode_e = ptm_mode_e'(mode);
      end else begin : g_mode_noexp
         assign mode_e = (mode == 3'b100) ? MODE_OFF : ptm_mode_e'(mode);
      end
   endgenerate

   ptm_locator #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_locator (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .stb     (stb_eff),
      .mode_e  (mode_e),
      .byte_in (trace_byte),
      .wr_en   (loc_wr),
      .wr_loc  (loc_idx)
   );

   ptm_persist #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_persist (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .active    (mode_e == MODE_PERSIST),
      .stb       (stb_eff),
      .byte_in   (trace_byte),
      .thresh    (persist_n),
      .loc0_byte (loc0_byte),
      .accept    (p_accept)
   );

   assign st_wr  = loc_wr || p_accept;
   assign st_loc = p_accept ? '0 : loc_idx;

   ptm_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .HAS_EXPECT(HAS_EXPECT)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (restart),
      .wr_en       (st_wr),
      .wr_loc      (st_loc),
      .wr_data     (trace_byte),
      .exp_wr_en   (exp_wr_en),
      .exp_wr_addr (exp_wr_addr),
      .exp_wr_data (exp_wr_data),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .hist_byte   (hist_byte),
      .hist_valid  (hist_valid),
      .exp_byte    (exp_byte),
      .loc0_byte   (loc0_byte)
   );

   always_comb begin
      ref_byte  = (mode_e == MODE_EXPECT) ? exp_byte : hist_byte;
      ref_valid = (mode_e == MODE_EXPECT) || hist_valid;
      bad       = ref_valid && (ref_byte != trace_byte);
      mis_n     = mis_q;
      clean_n   = clean_q;
      if (restart) begin
         mis_n   = 1'b0;
         clean_n = '0;
      end else if (loc_wr) begin
         case (mode_e)
            MODE_RROBIN: mis_n = bad;
            MODE_CRLF, MODE_MSB, MODE_EXPECT: begin
               if (bad) begin
                  mis_n   = 1'b1;
                  clean_n = '0;
               end else if (clean_q == CLW'(DEPTH - 1)) begin
                  mis_n   = 1'b0;
                  clean_n = '0;
               end else begin
                  clean_n = clean_q + CLW'(1);
               end
            end
            default: ;
         endcase
      end
      if ((mis_n != mis_q) || p_accept) dlt_n = 1'b1;
      else if (delta_clr)               dlt_n = 1'b0;
      else                              dlt_n = dlt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 3'b000;
         mis_q   <= 1'b0;
         dlt_q   <= 1'b0;
         clean_q <= '0;
      end else begin
         mode_q  <= mode;
         mis_q   <= mis_n;
         dlt_q   <= dlt_n;
         clean_q <= clean_n;
      end
   end

   assign mismatch = mis_q;
   assign delta    = dlt_q;
   assign irq      = dlt_q && !irq_mask;

endmodule

// File: rtl/ptm_checker.sv
module ptm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] mode,
   input logic       frame_stb,
   input logic       delta_clr,
   input logic       mismatch,
   input logic       delta
);

   // R9 and R8: modes without a mismatch state leave it at zero
   a_r9_idle_modes_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b011 || mode > 3'b100) |=> !mismatch);

   // R11: every move of the mismatch state is flagged
   a_r11_delta_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mismatch) |-> delta);

   // R5: the state moves only on a byte or a mode change
   a_r5_hold_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && $stable(mode)) |=> $stable(mismatch));

   // R11: a clear with no event empties the delta bit
   a_r11_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_clr && !frame_stb && $stable(mode)) |=> !delta);

   // R11: delta is sticky while nothing happens
   a_r11_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!delta_clr && !frame_stb && $stable(mode)) |=> $stable(delta));

endmodule

bind trace_monitor ptm_checker u_ptm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .frame_stb (frame_stb),
   .delta_clr (delta_clr),
   .mismatch  (mismatch),
   .delta     (delta)
);

// File: tb/test_trace_monitor.sv
module test_trace_monitor;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'b000;
   logic [3:0] persist_n = 4'd3;
   logic       frame_stb = 1'b0;
   logic [7:0] trace_byte = 8'h00;
   logic       exp_wr_en = 1'b0;
   logic [5:0] exp_wr_addr = '0;
   logic [7:0] exp_wr_data = '0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       delta_clr = 1'b0;
   logic       irq_mask = 1'b0;
   logic       mismatch, delta, irq;

   trace_monitor i_trace_monitor (
      .clk(clk), .rst_n(rst_n), .mode(mode), .persist_n(persist_n),
      .frame_stb(frame_stb), .trace_byte(trace_byte),
      .exp_wr_en(exp_wr_en), .exp_wr_addr(exp_wr_addr), .exp_wr_data(exp_wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .delta_clr(delta_clr),
      .irq_mask(irq_mask), .mismatch(mismatch), .delta(delta), .irq(irq)
   );

   always #(CLK_P/2) clk = ~clk;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // ---------------- behavioural reference ----------------
   logic [7:0] mbuf [0:63];
   bit         mseen [0:63];
   logic [7:0] mexp [0:63];
   logic [2:0] m_mode;
   bit         m_al, m_mis, m_dlt;
   int         m_idx, m_clean, m_pcnt;
   logic [7:0] m_prev, m_cand;

   task automatic m_restart();
      m_al = 0; m_idx = 0; m_prev = 0; m_clean = 0; m_cand = 0; m_pcnt = 0;
      for (int i = 0; i < 64; i++) mseen[i] = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin mbuf[i] = 0; mexp[i] = 0; end
         m_restart();
         m_mode = 3'b000; m_mis = 0; m_dlt = 0;
      end else begin
         bit nmis, acc, wr, bad, refv;
         int loc, need;
         logic [7:0] b, rb;
         nmis = m_mis; acc = 0; wr = 0; loc = 0; b = trace_byte;
         if (mode != m_mode) begin
            m_mode = mode; m_restart(); nmis = 0;
         end else if (frame_stb) begin
            case (mode)
               3'd0: begin loc = m_idx; wr = 1; m_idx = (m_idx + 1) % 64; end
               3'd1, 3'd4: begin
                  loc = m_idx;
                  if (m_al) begin wr = 1; m_idx = (m_idx + 1) % 64; end
                  if (m_prev == 8'h0D && b == 8'h0A) begin m_al = 1; m_idx = 0; end
                  m_prev = b;
               end
               3'd2: begin
                  if (b[7]) begin loc = 0; wr = 1; m_idx = 1; m_al = 1; end
                  else if (m_al) begin loc = m_idx; wr = 1; m_idx = (m_idx + 1) % 64; end
               end
               3'd3: begin
                  if (b == m_cand) begin if (m_pcnt < 15) m_pcnt++; end
                  else begin m_cand = b; m_pcnt = 1; end
                  need = (persist_n == 0) ? 1 : int'(persist_n);
                  if (m_pcnt >= need && b != mbuf[0]) begin mbuf[0] = b; mseen[0] = 1; acc = 1; end
               end
               default: ;
            endcase
            if (wr) begin
               rb   = (mode == 3'd4) ? mexp[loc] : mbuf[loc];
               refv = (mode == 3'd4) || mseen[loc];
               bad  = refv && (rb != b);
               if (mode == 3'd0) nmis = bad;
               else if (bad) begin nmis = 1; m_clean = 0; end
               else begin
                  m_clean++;
                  if (m_clean == 64) begin nmis = 0; m_clean = 0; end
               end
               mbuf[loc] = b; mseen[loc] = 1;
            end
         end
         if (nmis != m_mis || acc) m_dlt = 1;
         else if (delta_clr) m_dlt = 0;
         m_mis = nmis;
         if (exp_wr_en) mexp[exp_wr_addr] = exp_wr_data;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // compare against the model on every clock, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_P/4);
      if (rst_n && !done) begin
         chk(cur_req, "mismatch", 32'(mismatch), 32'(m_mis));
         chk(cur_req, "delta", 32'(delta), 32'(m_dlt));
         chk((irq_mask ? "R12" : cur_req), "irq", 32'(irq), 32'(m_dlt && !irq_mask));
         chk(cur_req, "rd_data", 32'(rd_data), 32'(mbuf[rd_addr]));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [7:0] msg_s(input int k);
      if (k == 62) return 8'h0D;
      if (k == 63) return 8'h0A;
      return 8'h41 + 8'(k % 26);
   endfunction

   function automatic logic [7:0] msg_h(input int k);
      if (k == 0) return 8'hD0;
      return 8'h30 + 8'(k % 40);
   endfunction

   task automatic send(input logic [7:0] b);
      @(negedge clk); frame_stb = 1'b1; trace_byte = b; delta_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); frame_stb = 1'b0; delta_clr = 1'b0; exp_wr_en = 1'b0;
      end
   endtask

   task automatic clr_delta();
      @(negedge clk); frame_stb = 1'b0; delta_clr = 1'b1;
      @(negedge clk); delta_clr = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk); frame_stb = 1'b0; mode = m;
   endtask

   task automatic sweep();
      for (int i = 0; i < 64; i++) begin
         @(negedge clk); frame_stb = 1'b0; rd_addr = 6'(i);
      end
   endtask

   task automatic peek(input string req, input int a, input logic [7:0] e);
      @(negedge clk); frame_stb = 1'b0; rd_addr = 6'(a);
      #1 chk(req, "buffer read", 32'(rd_data), 32'(e));
   endtask

   task automatic s_pass(input int bad_k, input logic [7:0] bad_v);
      for (int k = 0; k < 64; k++) send((k == bad_k) ? bad_v : msg_s(k));
   endtask

   task automatic h_pass(input int bad_k, input logic [7:0] bad_v);
      for (int k = 0; k < 64; k++) send((k == bad_k) ? bad_v : msg_h(k));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      #1;
      chk("R1", "mismatch", 32'(mismatch), 0);
      chk("R1", "delta", 32'(delta), 0);
      chk("R1", "irq", 32'(irq), 0);
      chk("R1", "rd_data", 32'(rd_data), 0);

      // R2: round-robin history
      cur_req = "R2";
      for (int p = 0; p < 2; p++) for (int k = 0; k < 64; k++) send(8'(k * 3 + 1));
      send(8'(1)); send(8'hEE); send(8'(7));    // location 1 wrong
      idle(1);
      chk("R2", "mismatch after good byte", 32'(mismatch), 0);
      chk("R2", "delta after excursion", 32'(delta), 1);
      peek("R2", 1, 8'hEE);
      cur_req = "R11";
      clr_delta();
      chk("R11", "delta cleared", 32'(delta), 0);
      cur_req = "R2";
      send(8'h99);                               // location 3 wrong, stays set
      idle(1);
      chk("R2", "mismatch held", 32'(mismatch), 1);

      // R10: mode change clears state and drops the byte of that clock
      cur_req = "R10";
      @(negedge clk); mode = 3'b001; frame_stb = 1'b1; trace_byte = 8'h0D;
      send(8'h0A);
      for (int k = 0; k < 5; k++) send(8'h55);
      idle(1);
      chk("R10", "mismatch cleared on mode change", 32'(mismatch), 0);
      chk("R10", "delta on forced clear", 32'(delta), 1);
      clr_delta();

      // R3: CR/LF alignment
      cur_req = "R3";
      send(8'h0D); send(8'h0A);
      s_pass(-1, 8'h00); s_pass(-1, 8'h00);
      idle(1);
      peek("R3", 0, 8'h41);
      peek("R3", 5, 8'h46);
      peek("R3", 62, 8'h0D);
      peek("R3", 63, 8'h0A);
      sweep();
      // R5 / R6: a fault sets at once and clears after a clean full pass
      cur_req = "R5";
      s_pass(10, 8'h7E);
      idle(1);
      chk("R5", "mismatch after fault", 32'(mismatch), 1);
      cur_req = "R6";
      s_pass(-1, 8'h00);
      idle(1);
      chk("R6", "still set after one pass", 32'(mismatch), 1);
      s_pass(-1, 8'h00);
      idle(1);
      chk("R6", "cleared after clean pass", 32'(mismatch), 0);

      // R4: MSB-marked alignment, with masked interrupt (R12)
      cur_req = "R4";
      set_mode(3'b010);
      idle(1);
      clr_delta();
      send(8'h11); send(8'h12); send(8'h13);
      h_pass(-1, 8'h00); h_pass(-1, 8'h00);
      idle(1);
      peek("R4", 0, 8'hD0);
      peek("R4", 1, 8'h31);
      sweep();
      cur_req = "R12";
      @(negedge clk); irq_mask = 1'b1;
      h_pass(20, 8'h01);
      idle(1);
      chk("R12", "delta under mask", 32'(delta), 1);
      chk("R12", "irq masked", 32'(irq), 0);
      @(negedge clk); irq_mask = 1'b0;
      #1 chk("R12", "irq unmasked", 32'(irq), 1);
      cur_req = "R5";
      h_pass(-1, 8'h00); h_pass(-1, 8'h00);
      idle(1);
      chk("R6", "MSB mode clears", 32'(mismatch), 0);

      // R7: expected message
      cur_req = "R7";
      set_mode(3'b100);
      for (int k = 0; k < 64; k++) begin
         @(negedge clk); frame_stb = 1'b0;
         exp_wr_en = 1'b1; exp_wr_addr = 6'(k); exp_wr_data = msg_s(k);
      end
      idle(1);
      clr_delta();
      send(8'h0D); send(8'h0A);
      s_pass(-1, 8'h00); s_pass(-1, 8'h00);
      idle(1);
      chk("R7", "matching message", 32'(mismatch), 0);
      @(negedge clk); exp_wr_en = 1'b1; exp_wr_addr = 6'd20; exp_wr_data = 8'h00;
      idle(1);
      s_pass(-1, 8'h00);
      idle(1);
      chk("R7", "expected byte differs", 32'(mismatch), 1);
      @(negedge clk); exp_wr_en = 1'b1; exp_wr_addr = 6'd20; exp_wr_data = msg_s(20);
      idle(1);
      s_pass(-1, 8'h00);
      idle(1);
      chk("R7", "one clean pass clears", 32'(mismatch), 0);
      sweep();

      // R8: persistence filter
      cur_req = "R8";
      set_mode(3'b011);
      @(negedge clk); persist_n = 4'd3; frame_stb = 1'b0;
      clr_delta();
      send(8'h55); send(8'h55); send(8'h66); send(8'h66);
      idle(1);
      chk("R8", "not yet accepted", 32'(delta), 0);
      peek("R8", 0, 8'h41);
      send(8'h66);
      idle(1);
      chk("R8", "accepted after three", 32'(delta), 1);
      chk("R8", "mismatch unused", 32'(mismatch), 0);
      peek("R8", 0, 8'h66);
      clr_delta();
      send(8'h66); send(8'h77); send(8'h77); send(8'h66);
      idle(1);
      chk("R8", "same value not re-reported", 32'(delta), 0);
      @(negedge clk); persist_n = 4'd0;
      send(8'h12); send(8'h34);
      idle(1);
      peek("R8", 0, 8'h34);
      clr_delta();

      // R9: disabled codes
      cur_req = "R9";
      for (int m = 5; m < 8; m++) begin
         set_mode(3'(m));
         for (int k = 0; k < 8; k++) send(8'hF0 + 8'(k));
         idle(1);
         chk("R9", "mismatch stays low", 32'(mismatch), 0);
         peek("R9", 0, 8'h34);
      end
      sweep();
      idle(2);
      finish_run();
   end

endmodule